// File: doc/BRIEF.md
# Interval Timer with Standby Wake

This block is an 8-bit up-counter fed by a clock prescaler. A 3-bit rate select picks one of eight prescaler ratios, and the counter advances once per selected tick. The block has two uses. In interval mode, software enables the timer and gets a sticky interrupt request each time the counter wraps. The request stays set until software clears it.

The same counter also serves the low-power path. A standby request is granted only while the timer is disabled. Once the chip is in standby, a non-maskable wake input restarts the counter from zero at the rate that was selected before standby began. The first wrap marks the oscillator as settled. The block then gives a one-cycle clock-release pulse, leaves standby and returns to normal operation. Configuration writes are ignored during standby and recovery, so the settling interval cannot be altered.

Top module: `standby_wake_timer`

## Requirements
- R1: After synchronous reset, `tcount` is 0x00 and `irq`, `stby_ok` and `clk_release` are all 0.
- R2: Rate select value s gives a divide ratio D = 2^DIV_LOG2[s]. After the edge that writes run=1, `tcount` stays 0 for D-1 cycles and reads 1 exactly D cycles after that edge.
- R3: With run=1 and mode=0, `irq` is set exactly at the edge where `tcount` wraps from 0xFF to 0x00. This is 256·D cycles after the enabling write, and the wrap repeats every 256·D cycles.
- R4: `irq` is sticky. A one-cycle `irq_clr` pulse clears it at that edge. If an overflow falls on the same edge, the set wins.
- R5: With run=1 and mode=1, the counter runs and wraps but `irq` is never set.
- R6: While not in standby and run=0, `tcount` is forced to 0x00 one edge after run is cleared, and the prescaler phase restarts.
- R7: A `stby_req` sampled while run=1 is refused and `stby_ok` stays 0. When run=0, `stby_ok` is 1 from the edge that samples the request.
- R8: In standby, a `wake_nmi` sample starts the counter from 0x00 at the pre-standby rate. `clk_release` rises exactly 256·D cycles after the edge that sampled `wake_nmi`. Outside standby, `wake_nmi` has no effect.
- R9: Configuration writes are ignored while `stby_ok` is 1, and the rate is retained. Writes take effect again once standby ends.
- R10: `clk_release` lasts exactly one cycle. `stby_ok` falls at that same edge. The recovery wrap never sets `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration fields |
| cfg_run | input | 1 | Timer enable field |
| cfg_mode | input | 1 | 0 = interval interrupts, 1 = count without interrupt |
| cfg_rate | input | SEL_W | Prescaler rate select |
| irq_clr | input | 1 | Clear pulse for the sticky interrupt flag |
| wake_nmi | input | 1 | Non-maskable wake request |
| stby_req | input | 1 | Request to enter standby |
| tcount | output | CNT_W | Current counter value |
| irq | output | 1 | Sticky interval interrupt request |
| stby_ok | output | 1 | High from standby entry until clock release |
| clk_release | output | 1 | One-cycle pulse when the settling time has elapsed |

## Verification
Every result is registered and lands at a fixed edge. The first count arrives D edges after the enabling write. The interrupt arrives 256·D edges after it. `stby_ok` follows one edge after the request, and the release pulse 256·D edges after the wake sample. The bench drives inputs on the falling edge and samples on later falling edges. It checks the cycle just before each due edge and then the due edge itself, so an off-by-one shows up on either side. The prescaler ratios are overridden to 1 through 128 so that every rate select can be swept through a full wrap. The recovery interval is timed edge by edge against the rate selected before standby.

// File: rtl/swt_pkg.sv
package swt_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_STANDBY = 2'd1,
    ST_RECOVER = 2'd2
  } swt_state_e;
endpackage

// File: rtl/swt_prescaler.sv
module swt_prescaler #(
  parameter int SEL_W = 3,
  parameter int PRE_W = 14,
  parameter int unsigned DIV_LOG2 [2**SEL_W] = '{1, 6, 7, 8, 9, 10, 12, 13}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL = 2**SEL_W;

  logic [PRE_W-1:0] phase_q;
  logic [NSEL-1:0]  tick_vec;

  always_ff @(posedge clk) begin
    if (rst || !active) phase_q <= '0;
    else                phase_q <= phase_q + 1'b1;
  end

  // one tap per ratio: fires when the low bits of the phase are all ones
  for (genvar g = 0; g < NSEL; g++) begin : g_tap
    localparam logic [PRE_W-1:0] MASK = PRE_W'((64'd1 << DIV_LOG2[g]) - 64'd1);
    assign tick_vec[g] = active && ((phase_q & MASK) == MASK);
  end

  assign tick = tick_vec[sel];
endmodule

// File: rtl/swt_counter.sv
module swt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || !active) cnt <= '0;
    else if (tick)      cnt <= cnt + 1'b1;
  end

  assign ovf = active && tick && (cnt == TOP);
endmodule

// File: rtl/swt_ctrl.sv
module swt_ctrl
  import swt_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_run,
  input  logic             cfg_mode,
  input  logic [SEL_W-1:0] cfg_rate,
  input  logic             irq_clr,
  input  logic             wake_nmi,
  input  logic             stby_req,
  input  logic             ovf,
  output logic             en_q,
  output logic             mode_q,
  output logic [SEL_W-1:0] rate_q,
  output logic             count_active,
  output swt_state_e       state_q,
  output logic             irq,
  output logic             stby_ok,
  output logic             clk_release
);
  swt_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (stby_req && !en_q) state_d = ST_STANDBY;
      ST_STANDBY: if (wake_nmi)          state_d = ST_RECOVER;
      ST_RECOVER: if (ovf)               state_d = ST_RUN;
      default:                           state_d = ST_RUN;
    endcase
  end

  assign count_active = (state_q == ST_RECOVER) || ((state_q == ST_RUN) && en_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RUN;
      en_q        <= 1'b0;
      mode_q      <= 1'b0;
      rate_q      <= '0;
      irq         <= 1'b0;
      stby_ok     <= 1'b0;
      clk_release <= 1'b0;
    end else begin
      state_q     <= state_d;
      stby_ok     <= (state_d != ST_RUN);
      clk_release <= (state_q == ST_RECOVER) && ovf;
      if (cfg_wr && state_q == ST_RUN) begin
        en_q   <= cfg_run;
        mode_q <= cfg_mode;
        rate_q <= cfg_rate;
      end
      if (state_q == ST_RUN && en_q && !mode_q && ovf) irq <= 1'b1;
      else if (irq_clr)                                irq <= 1'b0;
    end
  end
endmodule

// File: rtl/standby_wake_timer.sv
module standby_wake_timer
  import swt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3,
  parameter int unsigned DIV_LOG2 [2**SEL_W] = '{1, 6, 7, 8, 9, 10, 12, 13}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_run,
  input  logic             cfg_mode,
  input  logic [SEL_W-1:0] cfg_rate,
  input  logic             irq_clr,
  input  logic             wake_nmi,
  input  logic             stby_req,
  output logic [CNT_W-1:0] tcount,
  output logic             irq,
  output logic             stby_ok,
  output logic             clk_release
);
  function automatic int max_log2();
    int m = 0;
    for (int i = 0; i < 2**SEL_W; i++)
      if (int'(DIV_LOG2[i]) > m) m = int'(DIV_LOG2[i]);
    return m;
  endfunction

  localparam int PRE_W = max_log2() + 1;

  logic             en_q, mode_q, count_active, pre_tick, ovf;
  logic [SEL_W-1:0] rate_q;
  swt_state_e       state_q;

  swt_prescaler #(.SEL_W(SEL_W), .PRE_W(PRE_W), .DIV_LOG2(DIV_LOG2)) u_pre (
    .clk(clk), .rst(rst), .active(count_active), .sel(rate_q), .tick(pre_tick)
  );

  swt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .active(count_active), .tick(pre_tick),
    .cnt(tcount), .ovf(ovf)
  );

  swt_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_run(cfg_run), .cfg_mode(cfg_mode),
    .cfg_rate(cfg_rate), .irq_clr(irq_clr), .wake_nmi(wake_nmi), .stby_req(stby_req),
    .ovf(ovf), .en_q(en_q), .mode_q(mode_q), .rate_q(rate_q),
    .count_active(count_active), .state_q(state_q), .irq(irq), .stby_ok(stby_ok),
    .clk_release(clk_release)
  );
endmodule

// File: rtl/swt_checker.sv
module swt_checker #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             en_q,
  input logic             mode_q,
  input logic [SEL_W-1:0] rate_q,
  input logic             count_active,
  input logic [CNT_W-1:0] tcount,
  input logic             irq,
  input logic             stby_ok,
  input logic             clk_release
);
  // R7: standby is granted only when the timer was disabled
  a_r7_stby_needs_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(stby_ok) |-> !$past(en_q));

  // R10: release is a single-cycle pulse
  a_r10_release_pulse: assert property (@(posedge clk) disable iff (rst)
    clk_release |=> !clk_release);

  // R10: release coincides with leaving standby on a wrapped counter
  a_r10_release_exit: assert property (@(posedge clk) disable iff (rst)
    clk_release |-> (!stby_ok && tcount == '0));

  // R10: the interrupt never rises out of standby or recovery
  a_r10_no_irq_recover: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !$past(stby_ok));

  // R5: counting mode 1 never raises the interrupt
  a_r5_mode1_quiet: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !$past(mode_q));

  // R9: the rate select is frozen while in standby
  a_r9_rate_held: assert property (@(posedge clk) disable iff (rst)
    stby_ok |=> $stable(rate_q));

  // R6: an idle counter reads zero one edge later
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !count_active |=> (tcount == '0));
endmodule

bind standby_wake_timer swt_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_swt_chk (
  .clk(clk), .rst(rst), .en_q(en_q), .mode_q(mode_q), .rate_q(rate_q),
  .count_active(count_active), .tcount(tcount), .irq(irq), .stby_ok(stby_ok),
  .clk_release(clk_release)
);

// File: tb/tb_standby_wake_timer.sv
`timescale 1ns/1ps
module tb_standby_wake_timer;
  localparam int CNT_W = 8;
  localparam int SEL_W = 3;

  logic clk = 1'b0;
  logic rst, cfg_wr, cfg_run, cfg_mode, irq_clr, wake_nmi, stby_req;
  logic [SEL_W-1:0] cfg_rate;
  logic [CNT_W-1:0] tcount;
  logic irq, stby_ok, clk_release;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  standby_wake_timer #(.CNT_W(CNT_W), .SEL_W(SEL_W),
                       .DIV_LOG2('{0, 1, 2, 3, 4, 5, 6, 7})) dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_run(cfg_run), .cfg_mode(cfg_mode),
    .cfg_rate(cfg_rate), .irq_clr(irq_clr), .wake_nmi(wake_nmi), .stby_req(stby_req),
    .tcount(tcount), .irq(irq), .stby_ok(stby_ok), .clk_release(clk_release)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit run, input bit mode, input int rate);
    cfg_wr = 1'b1; cfg_run = run; cfg_mode = mode; cfg_rate = SEL_W'(rate);
    step(1);
    cfg_wr = 1'b0;
  endtask

  task automatic clr_irq();
    irq_clr = 1'b1;
    step(1);
    irq_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d;
    int first_rel;
    bit early_bad;
    rst = 1'b1; cfg_wr = 0; cfg_run = 0; cfg_mode = 0; cfg_rate = '0;
    irq_clr = 0; wake_nmi = 0; stby_req = 0;
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk(tcount == 0, "R1 tcount", tcount, 0);
    chk(irq == 0 && stby_ok == 0 && clk_release == 0, "R1 flags",
        {irq, stby_ok, clk_release}, 0);

    // R2 / R3 sweep over every rate select
    for (int s = 0; s < 8; s++) begin
      d = 1 << s;
      wr(0, 0, s);
      clr_irq();
      wr(1, 0, s);
      step(d - 1);
      chk(tcount == 0, "R2 before first tick", tcount, 0);
      step(1);
      chk(tcount == 1, "R2 first tick", tcount, 1);
      step(256 * d - d - 1);
      chk(tcount == 255 && irq == 0, "R3 before wrap", {irq, tcount}, 255);
      step(1);
      chk(tcount == 0 && irq == 1, "R3 at wrap", {irq, tcount}, 256);
      if (s == 0) begin
        clr_irq();
        chk(irq == 0, "R4 clear", irq, 0);
        step(254);
        chk(irq == 0, "R3 before second wrap", irq, 0);
        step(1);
        chk(irq == 1, "R3 second wrap", irq, 1);
      end
    end

    // R5 mode 1 counts without interrupt
    wr(0, 0, 0);
    clr_irq();
    wr(1, 1, 0);
    step(300);
    chk(tcount == 44, "R5 count", tcount, 44);
    chk(irq == 0, "R5 no irq", irq, 0);

    // R6 disable forces zero
    wr(0, 1, 0);
    step(1);
    chk(tcount == 0, "R6 cleared", tcount, 0);
    step(20);
    chk(tcount == 0, "R6 held", tcount, 0);

    // R8 wake ignored outside standby
    wr(1, 0, 0);
    step(10);
    wake_nmi = 1'b1;
    step(1);
    wake_nmi = 1'b0;
    chk(tcount == 11, "R8 nmi ignored in run", tcount, 11);
    chk(clk_release == 0 && stby_ok == 0, "R8 no release in run",
        {clk_release, stby_ok}, 0);

    // R7 refusal while enabled
    stby_req = 1'b1;
    step(5);
    chk(stby_ok == 0, "R7 refused", stby_ok, 0);
    stby_req = 1'b0;
    wr(0, 0, 3);
    clr_irq();
    stby_req = 1'b1;
    step(1);
    stby_req = 1'b0;
    chk(stby_ok == 1, "R7 granted", stby_ok, 1);

    // R9 writes ignored in standby
    wr(1, 0, 0);
    step(5);
    chk(tcount == 0 && stby_ok == 1, "R9 write ignored", {stby_ok, tcount}, 256);

    // R8 recovery at the retained rate (D = 8 -> 2048 cycles)
    wake_nmi = 1'b1;
    step(1);
    wake_nmi = 1'b0;
    first_rel = 0;
    early_bad = 0;
    for (int j = 1; j <= 2048; j++) begin
      step(1);
      if (clk_release && first_rel == 0) first_rel = j;
      if (j < 2048 && (stby_ok == 0 || irq == 1)) early_bad = 1;
    end
    chk(first_rel == 2048, "R8 release timing", first_rel, 2048);
    chk(!early_bad, "R10 standby held during recovery", early_bad, 0);
    chk(stby_ok == 0 && irq == 0, "R10 exit flags", {stby_ok, irq}, 0);
    step(1);
    chk(clk_release == 0, "R10 single pulse", clk_release, 0);
    chk(tcount == 0, "R9 ignored enable stayed off", tcount, 0);

    // R9 writes resume after standby
    wr(1, 0, 0);
    step(5);
    chk(tcount == 5, "R9 writes resume", tcount, 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule